// File: doc/BRIEF.md
# Three-Source Maskable Interrupt Controller

This block merges two external level-sensitive interrupt lines and a request pulse from an on-chip timer into a single interrupt request toward a processor core. Each source has a pending state. A small register window lets software read those pending states, and read or write a per-source mask. A write to the status location clears the timer's pending state. The two external lines are not latched: their pending state follows the line, sampled once per clock.

Among the unmasked pending sources, a fixed priority picks a winner. Its index is presented on a two-bit vector select next to the request. A global disable input, active low, blocks the request without touching the pending or mask state.

A separate non-maskable input is edge-latched. It stays pending until the core signals that it has taken it. It ignores both the mask and the global disable.

Top module: `irq_merge_ctrl`

## Requirements
- R1: After reset, the status read, the mask read, `nmi_pend`, `cpu_irq` and the held timer pending state are all zero.
- R2: A read at offset 3 returns the pending states in these bits: bit 0 is external line 2, bit 1 is external line 1, bit 2 is the timer; the upper bits read zero. Each external bit equals the level its line had at the previous rising clock edge.
- R3: A write at offset 2 stores data bits [2:0] as the mask, in the same bit order as the status. A read at offset 2 returns the stored mask with the upper bits zero.
- R4: A `tmr_fire` pulse sets the timer pending bit, and it stays set until any write to offset 3, whatever the data. When a fire and such a write fall in the same cycle, the bit is set.
- R5: Reads at offsets 0 and 1 return zero. Writes at offsets 0 and 1 change neither the mask nor the pending states.
- R6: `cpu_irq` is high exactly when at least one pending source has its mask bit at 0 and `irq_dis_n` is high. A mask bit of 1 only hides its source from the request; the status read still shows it.
- R7: While `cpu_irq` is high, `vec_sel` gives the winning source: 0 for the timer, 1 for external line 1, 2 for external line 2. The timer wins over line 1, and line 1 wins over line 2. `vec_sel` is 3 when no unmasked source is pending.
- R8: A rising edge on `nmi_in` sets `nmi_pend` one cycle later. A falling edge does not clear it. `nmi_taken` clears it, but an edge in the same cycle wins. The mask and `irq_dis_n` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext1_lvl | input | 1 | External interrupt line 1, level, active high |
| ext2_lvl | input | 1 | External interrupt line 2, level, active high |
| tmr_fire | input | 1 | One-cycle request pulse from the timer |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq_dis_n | input | 1 | Global disable, active low: when low, no request is raised |
| nmi_in | input | 1 | Non-maskable input, edge-sensitive |
| nmi_taken | input | 1 | Core has accepted the non-maskable interrupt |
| nmi_pend | output | 1 | Latched non-maskable request |
| cpu_irq | output | 1 | Maskable interrupt request to the core |
| vec_sel | output | 2 | Index of the winning source |

## Verification
Random cycles toggle all three sources, the mask, the gate and the register strobes together. This catches any mix-up between status bit order and priority order. It also catches a mask that also hides status, and an acknowledge that is sensitive to data or offset. Directed cases apply all three sources at once, then peel them away one by one to expose each priority rank. They hold a fire and an acknowledge in the same cycle, and drop `nmi_in` before and after `nmi_taken`. Together these separate an edge latch from a level follower, and set-wins from clear-wins.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
  localparam int NSRC     = 3;
  localparam int VEC_W    = 2;
  // status and mask bit positions
  localparam int BIT_EXT2 = 0;
  localparam int BIT_EXT1 = 1;
  localparam int BIT_TMR  = 2;
  // register offsets
  localparam logic [1:0] OFF_MASK = 2'd2;
  localparam logic [1:0] OFF_STAT = 2'd3;
  localparam logic [VEC_W-1:0] VEC_NONE = 2'd3;

  typedef logic [NSRC-1:0] src_vec_t;

  // priority rank p (0 = highest) maps onto bit index NSRC-1-p
  function automatic int rank_bit(input int p);
    return NSRC - 1 - p;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/irq_src_state.sv
module irq_src_state
  import irq_merge_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ext1_lvl,
  input  logic     ext2_lvl,
  input  logic     tmr_fire,
  input  logic     tmr_ack,
  output src_vec_t pend
);
  src_vec_t pend_q, pend_d;

  always_comb begin
    pend_d           = pend_q;
    pend_d[BIT_EXT1] = ext1_lvl;
    pend_d[BIT_EXT2] = ext2_lvl;
    if (tmr_fire)     pend_d[BIT_TMR] = 1'b1;
    else if (tmr_ack) pend_d[BIT_TMR] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_merge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  src_vec_t          pend,
  output src_vec_t          mask,
  output logic              tmr_ack,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int PAD_W = DATA_W - NSRC;

  src_vec_t mask_q, mask_d;
  logic     mask_en;

  assign mask_en = reg_wr && (reg_addr == OFF_MASK);
  assign tmr_ack = reg_wr && (reg_addr == OFF_STAT);

  always_comb begin
    mask_d = mask_q;
    if (mask_en) mask_d = reg_wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_comb begin
    case (reg_addr)
      OFF_MASK: reg_rdata = {{PAD_W{1'b0}}, mask_q};
      OFF_STAT: reg_rdata = {{PAD_W{1'b0}}, pend};
      default:  reg_rdata = '0;
    endcase
  end

  assign mask = mask_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_merge_pkg::*;
(
  input  src_vec_t         pend,
  input  src_vec_t         mask,
  input  logic             irq_dis_n,
  output logic             cpu_irq,
  output logic [VEC_W-1:0] vec_sel
);
  src_vec_t live;
  assign live = pend & ~mask;

  always_comb begin
    vec_sel = VEC_NONE;
    // walk from lowest rank up so the highest live rank is left standing
    for (int p = NSRC - 1; p >= 0; p--) begin
      if (live[rank_bit(p)]) vec_sel = VEC_W'(p);
    end
  end

  assign cpu_irq = (|live) & irq_dis_n;
endmodule

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic nmi_taken,
  output logic nmi_pend
);
  logic prev_q, prev_d;
  logic hold_q, hold_d;
  logic rise;

  assign rise = nmi_in & ~prev_q;

  always_comb begin
    prev_d = nmi_in;
    hold_d = hold_q;
    if (rise)           hold_d = 1'b1;
    else if (nmi_taken) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      hold_q <= hold_d;
    end
  end

  assign nmi_pend = hold_q;
endmodule

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl
  import irq_merge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext1_lvl,
  input  logic              ext2_lvl,
  input  logic              tmr_fire,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              irq_dis_n,
  input  logic              nmi_in,
  input  logic              nmi_taken,
  output logic              nmi_pend,
  output logic              cpu_irq,
  output logic [VEC_W-1:0]  vec_sel
);
  logic     rst_sync_n;
  logic     tmr_ack;
  src_vec_t pend;
  src_vec_t mask;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_src_state u_src (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ext1_lvl (ext1_lvl),
    .ext2_lvl (ext2_lvl),
    .tmr_fire (tmr_fire),
    .tmr_ack  (tmr_ack),
    .pend     (pend)
  );

  irq_mask_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .pend      (pend),
    .mask      (mask),
    .tmr_ack   (tmr_ack),
    .reg_rdata (reg_rdata)
  );

  irq_prio_sel u_prio (
    .pend      (pend),
    .mask      (mask),
    .irq_dis_n (irq_dis_n),
    .cpu_irq   (cpu_irq),
    .vec_sel   (vec_sel)
  );

  nmi_edge_latch u_nmi (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .nmi_in    (nmi_in),
    .nmi_taken (nmi_taken),
    .nmi_pend  (nmi_pend)
  );
endmodule

// File: rtl/irq_merge_ctrl_chk.sv
module irq_merge_ctrl_chk
  import irq_merge_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input src_vec_t         pend,
  input src_vec_t         mask,
  input logic [1:0]       reg_addr,
  input logic             reg_wr,
  input logic             tmr_fire,
  input logic             irq_dis_n,
  input logic             nmi_in,
  input logic             nmi_taken,
  input logic             nmi_pend,
  input logic             cpu_irq,
  input logic [VEC_W-1:0] vec_sel
);
  // R4: a status write without a fire leaves the timer clear
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == OFF_STAT && !tmr_fire) |=> !pend[BIT_TMR]);

  // R4: a fire always lands
  p_fire_sets_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tmr_fire |=> pend[BIT_TMR]);

  // R6: the global disable blocks the request
  p_gate_blocks_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !irq_dis_n |-> !cpu_irq);

  // R7: an unmasked pending timer always wins
  p_timer_wins_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_irq && pend[BIT_TMR] && !mask[BIT_TMR]) |-> vec_sel == 2'd0);

  // R8: a rising edge latches
  p_nmi_rise_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(nmi_in) |=> nmi_pend);

  // R8: only nmi_taken releases the latch
  p_nmi_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (nmi_pend && !nmi_taken) |=> nmi_pend);
endmodule

bind irq_merge_ctrl irq_merge_ctrl_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .pend       (pend),
  .mask       (mask),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .tmr_fire   (tmr_fire),
  .irq_dis_n  (irq_dis_n),
  .nmi_in     (nmi_in),
  .nmi_taken  (nmi_taken),
  .nmi_pend   (nmi_pend),
  .cpu_irq    (cpu_irq),
  .vec_sel    (vec_sel)
);

// File: tb/irq_merge_ctrl_bench.sv
`timescale 1ns/100ps
module irq_merge_ctrl_bench;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ext1_lvl, ext2_lvl, tmr_fire, reg_wr, irq_dis_n, nmi_in, nmi_taken;
  logic [1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata, reg_rdata;
  logic nmi_pend, cpu_irq;
  logic [1:0] vec_sel;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // model state, bit order: 0 line2, 1 line1, 2 timer
  logic [2:0] m_pend, m_mask;
  logic m_nmi, m_prev;

  always #2.5 clk = ~clk;

  irq_merge_ctrl #(.DATA_W(DATA_W)) u_irq_merge_ctrl (
    .clk(clk), .rst_n(rst_n), .ext1_lvl(ext1_lvl), .ext2_lvl(ext2_lvl),
    .tmr_fire(tmr_fire), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_dis_n(irq_dis_n),
    .nmi_in(nmi_in), .nmi_taken(nmi_taken), .nmi_pend(nmi_pend),
    .cpu_irq(cpu_irq), .vec_sel(vec_sel)
  );

  function automatic logic [DATA_W-1:0] f_rd(input logic [1:0] a,
      input logic [2:0] mk, input logic [2:0] pd);
    if (a == 2'd2) return {5'b0, mk};
    if (a == 2'd3) return {5'b0, pd};
    return '0;
  endfunction

  function automatic logic f_irq(input logic [2:0] pd, input logic [2:0] mk,
      input logic g);
    return (|(pd & ~mk)) & g;
  endfunction

  function automatic logic [1:0] f_vec(input logic [2:0] pd, input logic [2:0] mk);
    logic [2:0] lv;
    lv = pd & ~mk;
    if (lv[2]) return 2'd0;
    if (lv[1]) return 2'd1;
    if (lv[0]) return 2'd2;
    return 2'd3;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic model_step();
    logic rise;
    rise = nmi_in & ~m_prev;
    m_pend[0] = ext2_lvl;
    m_pend[1] = ext1_lvl;
    if (tmr_fire) m_pend[2] = 1'b1;
    else if (reg_wr && reg_addr == 2'd3) m_pend[2] = 1'b0;
    if (reg_wr && reg_addr == 2'd2) m_mask = reg_wdata[2:0];
    if (rise) m_nmi = 1'b1;
    else if (nmi_taken) m_nmi = 1'b0;
    m_prev = nmi_in;
  endtask

  task automatic compare(input string rd_tag);
    string t;
    if (rd_tag != "") t = rd_tag;
    else if (reg_addr == 2'd3) t = "R2";
    else if (reg_addr == 2'd2) t = "R3";
    else t = "R5";
    check(t, reg_rdata, f_rd(reg_addr, m_mask, m_pend));
    check("R6 cpu_irq", cpu_irq, f_irq(m_pend, m_mask, irq_dis_n));
    if (f_irq(m_pend, m_mask, irq_dis_n) || f_vec(m_pend, m_mask) == 2'd3)
      check("R7 vec_sel", vec_sel, f_vec(m_pend, m_mask));
    check("R8 nmi_pend", nmi_pend, m_nmi);
  endtask

  // inputs were driven at a falling edge; clock once, then compare
  task automatic step(input string rd_tag);
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    compare(rd_tag);
  endtask

  task automatic idle();
    ext1_lvl = 0; ext2_lvl = 0; tmr_fire = 0; reg_wr = 0; reg_wdata = '0;
    reg_addr = 2'd3; irq_dis_n = 1; nmi_in = 0; nmi_taken = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    idle();
    rst_n = 0;
    m_pend = '0; m_mask = '0; m_nmi = 0; m_prev = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    reg_addr = 2'd3; #0.1;
    check("R1 status", reg_rdata, 0);
    check("R1 cpu_irq", cpu_irq, 0);
    check("R1 nmi_pend", nmi_pend, 0);
    reg_addr = 2'd2; #0.1;
    check("R1 mask", reg_rdata, 0);

    // R3 only low 3 bits stored
    reg_wr = 1; reg_wdata = 8'hFF; step("R3");
    reg_wr = 0; step("R3");
    check("R3 mask ff", reg_rdata, 8'h07);
    reg_wr = 1; reg_wdata = 8'h00; step("R3");
    reg_wr = 0;

    // R7 all three, then peel
    ext1_lvl = 1; ext2_lvl = 1; tmr_fire = 1; reg_addr = 2'd3; step("R2");
    tmr_fire = 0; step("R2");
    check("R7 timer first", vec_sel, 2'd0);
    check("R2 status all", reg_rdata, 8'h07);
    reg_wr = 1; reg_wdata = 8'h00; step("R4");
    reg_wr = 0;
    check("R7 line1 second", vec_sel, 2'd1);
    check("R4 ack clears timer", reg_rdata, 8'h03);
    ext1_lvl = 0; step("R2");
    check("R7 line2 last", vec_sel, 2'd2);
    check("R2 line2 bit0", reg_rdata, 8'h01);

    // R6 mask hides request but not status (mask line2)
    reg_addr = 2'd2; reg_wr = 1; reg_wdata = 8'h01; step("R3");
    reg_wr = 0; reg_addr = 2'd3; step("R6");
    check("R6 masked no irq", cpu_irq, 0);
    check("R6 status still shows", reg_rdata, 8'h01);

    // R4 fire and ack together -> set
    tmr_fire = 1; reg_wr = 1; reg_wdata = 8'h5A; step("R4");
    tmr_fire = 0; reg_wr = 0; step("R4");
    check("R4 fire beats ack", reg_rdata[2], 1'b1);
    // R5 writes to offsets 0/1 do nothing
    reg_addr = 2'd0; reg_wr = 1; reg_wdata = 8'hFF; step("R5");
    reg_addr = 2'd1; step("R5");
    reg_wr = 0; reg_addr = 2'd2; step("R5");
    check("R5 mask untouched", reg_rdata, 8'h01);
    reg_addr = 2'd3; step("R5");
    check("R5 timer untouched", reg_rdata[2], 1'b1);

    // R6 gate low blocks, R8 nmi bypasses gate and mask
    irq_dis_n = 0; nmi_in = 1; step("R6");
    check("R6 gated", cpu_irq, 0);
    check("R8 nmi rise", nmi_pend, 1);
    nmi_in = 0; step("R8");
    check("R8 hold after drop", nmi_pend, 1);
    nmi_taken = 1; step("R8");
    check("R8 taken clears", nmi_pend, 0);
    nmi_taken = 0; irq_dis_n = 1; step("R8");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      ext1_lvl  = 1'($urandom_range(0, 1));
      ext2_lvl  = 1'($urandom_range(0, 1));
      tmr_fire  = ($urandom_range(0, 7) == 0);
      reg_wr    = ($urandom_range(0, 3) == 0);
      reg_addr  = 2'($urandom_range(0, 3));
      reg_wdata = 8'($urandom);
      irq_dis_n = ($urandom_range(0, 4) != 0);
      nmi_in    = ($urandom_range(0, 5) == 0) ? ~nmi_in : nmi_in;
      nmi_taken = ($urandom_range(0, 7) == 0);
      step("");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule